// File: doc/BRIEF.md
# Bus Hold Arbitration Controller

This block decides when the local bus may be handed to an external master. It samples a synchronous, level-sensitive hold request every clock. When the request is seen and the bus sits at a cycle boundary, it grants the bus. A boundary here means no cycle is in progress, or the cycle in progress ends this clock, and no locked sequence is running. On a grant it raises the hold-acknowledge output and pulls every bus output-enable low, so only the acknowledge itself stays driven. The bus is taken back one clock after the request is seen low.

Reset is synchronous and active high, and it overrides everything. It cancels an existing grant and ignores a pending request. It leaves the bus in the driven idle state, not in the high-impedance state. The non-maskable interrupt input is asynchronous, so it passes through a synchronizer. One rising edge seen while the bus is held is remembered. That edge appears on a pending flag when the bus is returned, and it stays there until the core takes it.

Top module: `hold_arbiter`

## Requirements
- R1: With the bus idle (`cyc_active`=0, `lock_active`=0), a clock that samples `hold_req`=1 sets `hold_ack`=1 on the next clock.
- R2: While `cyc_active`=1 and `cyc_done`=0, the request is not granted. When `cyc_done`=1 together with `hold_req`=1, `hold_ack` rises on the next clock.
- R3: While `lock_active`=1, `hold_ack` never rises, whatever `cyc_active` and `cyc_done` are.
- R4: Whenever `hold_ack`=1, all `bus_oe` bits are 0. Whenever `hold_ack`=0, all are 1. The bit order is 0 data, 1 byte enables, 2 address, 3 cycle type, 4 lock, 5 address strobe.
- R5: While held, `hold_ack` stays 1 as long as `hold_req`=1. One clock after `hold_req`=0 is sampled, `hold_ack`=0 and `bus_oe` is all ones.
- R6: One clock after `rst`=1 is sampled, `hold_ack`=0, `bus_oe` is all ones and `nmi_pend`=0. This holds even if the bus was held and `hold_req` is still 1.
- R7: `hold_req` is ignored while `rst`=1. After reset drops, a standing request is granted one clock later.
- R8: A rising edge on `nmi_in` while held sets `nmi_pend`=1 in the same clock that `hold_ack` falls.
- R9: Only one edge is remembered per hold. Once `nmi_take` clears `nmi_pend`, further edges from that same hold do not set it again.
- R10: An `nmi_in` level that was already high before the grant, with no new edge during the hold, does not set `nmi_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Level-sensitive request from the external master |
| cyc_active | input | 1 | A bus cycle is in progress |
| cyc_done | input | 1 | Ready ends the cycle in progress this clock |
| lock_active | input | 1 | A locked sequence is running |
| nmi_in | input | 1 | Asynchronous non-maskable interrupt line |
| nmi_take | input | 1 | The core accepts the pending interrupt |
| hold_ack | output | 1 | Bus granted to the external master |
| bus_oe | output | 6 | Output enables per bus group, in the bit order of R4 |
| nmi_pend | output | 1 | A remembered interrupt edge awaits processing |

## Verification
The grant decision is swept over all eight combinations of `cyc_active`, `cyc_done` and `lock_active` under a standing request. This separates a grant at a true boundary from a grant taken mid-cycle or inside a lock. Release is tried with the request held high for several clocks and then dropped, to tell level sensitivity apart from edge sensitivity. Reset is applied both from the idle state and from the held state while the request stays high. The interrupt input is tried in four ways: a level already high before the grant, a single edge, two edges within one hold, and an edge followed by a take. These show whether a genuine edge is remembered and whether a repeat edge is counted twice.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
  typedef enum logic {BUS_OWNED = 1'b0, BUS_HELD = 1'b1} own_e;
  localparam int OE_DATA  = 0;
  localparam int OE_BYTE  = 1;
  localparam int OE_ADDR  = 2;
  localparam int OE_CTYPE = 3;
  localparam int OE_LOCK  = 4;
  localparam int OE_STRB  = 5;
  localparam int OE_COUNT = 6;
endpackage

// File: rtl/hold_grant_fsm.sv
module hold_grant_fsm
  import hold_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic cyc_active,
  input  logic cyc_done,
  input  logic lock_active,
  output own_e state_q,
  output logic grant_evt,
  output logic release_evt
);
  logic at_boundary;

  assign at_boundary = !lock_active && (!cyc_active || cyc_done);

  always_comb begin
    grant_evt   = 1'b0;
    release_evt = 1'b0;
    if (!rst) begin
      if (state_q == BUS_OWNED) grant_evt   = hold_req && at_boundary;
      else                      release_evt = !hold_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              state_q <= BUS_OWNED;
    else if (grant_evt)   state_q <= BUS_HELD;
    else if (release_evt) state_q <= BUS_OWNED;
  end

  a_r3_no_grant_in_lock: assert property (@(posedge clk) disable iff (rst)
    (state_q == BUS_OWNED && lock_active) |=> state_q == BUS_OWNED);
  a_r2_no_grant_mid_cycle: assert property (@(posedge clk) disable iff (rst)
    (state_q == BUS_OWNED && cyc_active && !cyc_done) |=> state_q == BUS_OWNED);
endmodule

// File: rtl/bus_oe_bank.sv
module bus_oe_bank #(
  parameter int GROUPS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant_evt,
  input  logic              release_evt,
  output logic [GROUPS-1:0] oe_q
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_oe
    always_ff @(posedge clk) begin
      if (rst)              oe_q[g] <= 1'b1;
      else if (grant_evt)   oe_q[g] <= 1'b0;
      else if (release_evt) oe_q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/nmi_hold_latch.sv
module nmi_hold_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic held,
  input  logic release_evt,
  input  logic nmi_take,
  output logic nmi_pend
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         prev_q;
  logic         seen_q;
  logic         edge_w;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[TOP-1:0], nmi_in};
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[TOP];
  end

  assign edge_w = sync_q[TOP] && !prev_q;

  always_ff @(posedge clk) begin
    if (rst)                  seen_q <= 1'b0;
    else if (release_evt)     seen_q <= 1'b0;
    else if (held && edge_w)  seen_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                     nmi_pend <= 1'b0;
    else if (release_evt && (seen_q || edge_w))  nmi_pend <= 1'b1;
    else if (nmi_take)                           nmi_pend <= 1'b0;
  end

  a_r9_take_clears: assert property (@(posedge clk) disable iff (rst)
    (nmi_take && !release_evt) |=> !nmi_pend);
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
  import hold_arb_pkg::*;
#(
  parameter int GROUPS      = OE_COUNT,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_req,
  input  logic              cyc_active,
  input  logic              cyc_done,
  input  logic              lock_active,
  input  logic              nmi_in,
  input  logic              nmi_take,
  output logic              hold_ack,
  output logic [GROUPS-1:0] bus_oe,
  output logic              nmi_pend
);
  own_e state_q;
  logic grant_evt;
  logic release_evt;

  hold_grant_fsm u_fsm (
    .clk(clk), .rst(rst), .hold_req(hold_req), .cyc_active(cyc_active),
    .cyc_done(cyc_done), .lock_active(lock_active), .state_q(state_q),
    .grant_evt(grant_evt), .release_evt(release_evt)
  );

  bus_oe_bank #(.GROUPS(GROUPS)) u_oe (
    .clk(clk), .rst(rst), .grant_evt(grant_evt),
    .release_evt(release_evt), .oe_q(bus_oe)
  );

  nmi_hold_latch #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .held(state_q == BUS_HELD),
    .release_evt(release_evt), .nmi_take(nmi_take), .nmi_pend(nmi_pend)
  );

  assign hold_ack = (state_q == BUS_HELD);

  a_r6_reset_idle: assert property (@(posedge clk)
    rst |=> (!hold_ack && bus_oe == {GROUPS{1'b1}} && !nmi_pend));
  a_r4_ack_isolates: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> bus_oe == '0);
  a_r4_owned_drives: assert property (@(posedge clk) disable iff (rst)
    !hold_ack |-> bus_oe == {GROUPS{1'b1}});
  a_r5_release_next: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && !hold_req) |=> !hold_ack);
  a_r5_keep_held: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && hold_req) |=> hold_ack);
  a_r8_pend_on_release: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_pend) |-> $fell(hold_ack));
endmodule

// File: tb/hold_arbiter_bench.sv
module hold_arbiter_bench;
  logic clk = 1'b0;
  logic rst, hold_req, cyc_active, cyc_done, lock_active, nmi_in, nmi_take;
  logic hold_ack, nmi_pend;
  logic [5:0] bus_oe;
  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hold_arbiter u_hold_arbiter (
    .clk(clk), .rst(rst), .hold_req(hold_req), .cyc_active(cyc_active),
    .cyc_done(cyc_done), .lock_active(lock_active), .nmi_in(nmi_in),
    .nmi_take(nmi_take), .hold_ack(hold_ack), .bus_oe(bus_oe),
    .nmi_pend(nmi_pend)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_state(input string req, input logic ack, input logic pend);
    chk(req, {hold_ack, nmi_pend, bus_oe}, {ack, pend, ack ? 6'h00 : 6'h3F});
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; hold_req = 1; cyc_active = 0; cyc_done = 0;
    lock_active = 0; nmi_in = 0; nmi_take = 0;
    tick(3);
    chk_state("R6 reset state", 0, 0);
    chk_state("R7 request ignored in reset", 0, 0);
    rst = 0;
    tick(1);
    chk_state("R7 grant after reset", 1, 0);
    hold_req = 0;
    tick(1);
    chk_state("R5 release", 0, 0);

    // R1 R2 R3 sweep over cycle and lock inputs
    for (int k = 0; k < 8; k++) begin
      logic exp_grant;
      cyc_active = k[0]; cyc_done = k[1]; lock_active = k[2];
      exp_grant = !k[2] && (!k[0] || k[1]);
      hold_req = 1;
      tick(1);
      chk_state(k[2] ? "R3 lock sweep" : (k[0] ? "R2 cycle sweep" : "R1 idle sweep"),
                exp_grant, 0);
      hold_req = 0; cyc_active = 0; cyc_done = 0; lock_active = 0;
      tick(1);
      if (exp_grant) chk_state("R5 sweep release", 0, 0);
    end

    // R2 wait several clocks mid-cycle, then end it
    hold_req = 1; cyc_active = 1; cyc_done = 0;
    tick(4);
    chk_state("R2 waits mid-cycle", 0, 0);
    cyc_done = 1;
    tick(1);
    chk_state("R2 grant after done", 1, 0);
    cyc_active = 0; cyc_done = 0;
    tick(5);
    chk_state("R5 stays held", 1, 0);
    hold_req = 0;
    tick(1);
    chk_state("R5 release after hold", 0, 0);

    // R10 level already high before grant
    nmi_in = 1;
    tick(5);
    hold_req = 1;
    tick(5);
    hold_req = 0;
    tick(1);
    chk_state("R10 no edge no pend", 0, 0);
    nmi_in = 0;
    tick(4);

    // R8 single edge
    hold_req = 1;
    tick(1);
    nmi_in = 1;
    tick(5);
    chk_state("R8 not shown while held", 1, 0);
    hold_req = 0;
    tick(1);
    chk_state("R8 pend at release", 0, 1);
    nmi_take = 1;
    tick(1);
    nmi_take = 0;
    chk_state("R9 take clears", 0, 0);
    nmi_in = 0;
    tick(4);

    // R9 two edges in one hold, counted once
    hold_req = 1;
    tick(1);
    nmi_in = 1; tick(4); nmi_in = 0; tick(4);
    nmi_in = 1; tick(4); nmi_in = 0; tick(4);
    hold_req = 0;
    tick(1);
    chk_state("R9 pend after two edges", 0, 1);
    nmi_take = 1;
    tick(1);
    nmi_take = 0;
    tick(3);
    chk_state("R9 second edge not counted", 0, 0);

    // R6 reset while held with request still high
    hold_req = 1;
    tick(1);
    nmi_in = 1;
    tick(4);
    chk_state("R6 held before reset", 1, 0);
    rst = 1;
    tick(1);
    chk_state("R6 reset exits hold", 0, 0);
    tick(2);
    chk_state("R7 still ignored in reset", 0, 0);
    rst = 0;
    tick(1);
    chk_state("R7 regrant after reset", 1, 0);
    hold_req = 0;
    tick(1);
    chk_state("R6 reset dropped captured edge", 0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule